// File: doc/BRIEF.md
# Load Speculation Confidence Table

This block holds one small saturating confidence counter per load instruction. When a load has received a store-to-load dependence prediction, its program counter is presented on the lookup port. One cycle later the block answers with the load's current confidence level and a flag. The flag says whether the level has reached a configured threshold, so that the load may be allowed to take the forwarded value speculatively.

Once the prediction for a load has been checked, the outcome is written back on the update port. A correct prediction raises the count by an amount that depends on how the load forms its address: ordinary loads add one, stack-pointer-based loads add a configured stack step, and global-pointer-based loads add a configured global step. A wrong prediction clears the count. The threshold and both steps are run-time configuration inputs.

The table is direct-mapped. The index is PC bits [ALIGN+IDX_W-1:ALIGN] (bits [7:2] by default). The tag is the XOR-fold of every other PC bit into TAG_W bits: the non-index bits are taken from bit 0 upward, and the n-th of them is folded into tag bit n mod TAG_W.

Top module: `load_trust_table`

## Requirements
- R1: After reset every entry reads as level 0, so a lookup returns level 0 and a flag that is set only when the threshold is 0.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `lk_valid` high, and `rsp_level`/`rsp_trust` describe that lookup.
- R3: A correct update with class code 0 (ordinary) adds 1 to the entry's count.
- R4: A correct update with class code 1 (stack-pointer base) adds `cfg_inc_sp` to the count.
- R5: A correct update with class code 2 (global-pointer base) adds `cfg_inc_gp`; class code 3 is handled as ordinary and adds 1.
- R6: An update with `up_correct` low sets the entry's count to 0, whatever its class.
- R7: `rsp_trust` is 1 exactly when the returned level is greater than or equal to `cfg_thresh` as sampled with the lookup; a threshold of 0 trusts every lookup.
- R8: The count saturates at 2^CNT_W-1 (15 by default) and never wraps.
- R9: A lookup whose tag differs from the stored tag at its index returns level 0. An update whose tag differs takes over the entry, starting from a count of 0.
- R10: When an update and a lookup in the same cycle address the same index, the lookup returns the value after that update.
- R11: A step of 0 leaves the count unchanged on a correct prediction. The settings (threshold, stack step, global step) of (4,2,2), (8,4,4), (2,1,1), (1,1,1) and (0,0,0) are each supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_thresh | input | CNT_W | Level needed for the trust flag |
| cfg_inc_sp | input | CNT_W | Step for stack-pointer-based loads |
| cfg_inc_gp | input | CNT_W | Step for global-pointer-based loads |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | PC of the load being looked up |
| up_valid | input | 1 | Update request |
| up_pc | input | PC_W | PC of the load being updated |
| up_class | input | 2 | Addressing class: 0 ordinary, 1 stack, 2 global, 3 ordinary |
| up_correct | input | 1 | 1 if the predicted sourcing store was right |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_trust | output | 1 | Level at or above threshold |
| rsp_level | output | CNT_W | Confidence level of the looked-up load |

## Verification
Directed sequences first walk single PCs through each class. These separate the plain step from the two configured steps and from the clear on a wrong prediction. Saturation, a take-over by a PC with another tag, and a same-cycle update and lookup on one entry are also driven directly. Random traffic then draws from a small pool of PCs that share indices but differ in tag, under each of the five required settings. That traffic mixes collisions, bypass cycles and a mostly-correct outcome stream, and it shows whether the threshold comparison and the per-class steps stay right over long histories.

// File: rtl/ltt_pkg.sv
package ltt_pkg;
  typedef enum logic [1:0] {
    CLS_PLAIN  = 2'd0,
    CLS_STACK  = 2'd1,
    CLS_GLOBAL = 2'd2,
    CLS_OTHER  = 2'd3
  } ld_class_e;
endpackage

// File: rtl/ltt_step.sv
module ltt_step
  import ltt_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] old_cnt,
  input  logic             old_hit,
  input  logic             correct,
  input  ld_class_e        cls,
  input  logic [CNT_W-1:0] inc_sp,
  input  logic [CNT_W-1:0] inc_gp,
  output logic [CNT_W-1:0] new_cnt
);
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] step;
  logic [CNT_W:0]   sum;

  always_comb begin
    base = old_hit ? old_cnt : '0;
    unique case (cls)
      CLS_STACK:  step = inc_sp;
      CLS_GLOBAL: step = inc_gp;
      default:    step = CNT_W'(1);
    endcase
    sum = {1'b0, base} + {1'b0, step};
    if (!correct)        new_cnt = '0;
    else if (sum[CNT_W]) new_cnt = '1;
    else                 new_cnt = sum[CNT_W-1:0];
  end
endmodule

// File: rtl/ltt_store.sv
module ltt_store #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [TAG_W-1:0] wtag,
  input  logic [CNT_W-1:0] wcnt,
  input  logic [IDX_W-1:0] ridx_a,
  output logic             a_vld,
  output logic [TAG_W-1:0] a_tag,
  output logic [CNT_W-1:0] a_cnt,
  input  logic [IDX_W-1:0] ridx_b,
  output logic             b_vld,
  output logic [TAG_W-1:0] b_tag,
  output logic [CNT_W-1:0] b_cnt
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [CNT_W-1:0] cnt_mem [DEPTH];
  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[widx] <= wtag;
      cnt_mem[widx] <= wcnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     vld_q <= '0;
    else if (we) vld_q[widx] <= 1'b1;
  end

  assign a_vld = vld_q[ridx_a];
  assign a_tag = tag_mem[ridx_a];
  assign a_cnt = cnt_mem[ridx_a];
  assign b_vld = vld_q[ridx_b];
  assign b_tag = tag_mem[ridx_b];
  assign b_cnt = cnt_mem[ridx_b];
endmodule

// File: rtl/ltt_probe.sv
module ltt_probe #(
  parameter int TAG_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             ent_vld,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [CNT_W-1:0] ent_cnt,
  input  logic [TAG_W-1:0] want_tag,
  input  logic [CNT_W-1:0] thresh,
  output logic             rsp_valid,
  output logic             rsp_trust,
  output logic [CNT_W-1:0] rsp_level
);
  logic [CNT_W-1:0] level_c;

  assign level_c = (ent_vld && ent_tag == want_tag) ? ent_cnt : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_trust <= 1'b0;
      rsp_level <= '0;
    end else begin
      rsp_valid <= req;
      if (req) begin
        rsp_level <= level_c;
        rsp_trust <= (level_c >= thresh);
      end
    end
  end

  // R2: answer follows request by exactly one cycle
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req |=> rsp_valid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !req |=> !rsp_valid);
  // R7: flag agrees with the threshold presented alongside the request
  a_r7_trust_vs_thresh: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_trust == (rsp_level >= $past(thresh))));
endmodule

// File: rtl/load_trust_table.sv
module load_trust_table
  import ltt_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int ALIGN = 2,
  parameter int IDX_W = 6,
  parameter int TAG_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_thresh,
  input  logic [CNT_W-1:0] cfg_inc_sp,
  input  logic [CNT_W-1:0] cfg_inc_gp,
  input  logic             lk_valid,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic             up_valid,
  input  logic [PC_W-1:0]  up_pc,
  input  logic [1:0]       up_class,
  input  logic             up_correct,
  output logic             rsp_valid,
  output logic             rsp_trust,
  output logic [CNT_W-1:0] rsp_level
);
  localparam int IDX_LO = ALIGN;
  localparam int IDX_HI = ALIGN + IDX_W;

  function automatic logic [TAG_W-1:0] fold_tag(input logic [PC_W-1:0] pc);
    logic [TAG_W-1:0] t;
    int k;
    t = '0;
    k = 0;
    for (int i = 0; i < PC_W; i++) begin
      if (i < IDX_LO || i >= IDX_HI) begin
        t[k % TAG_W] = t[k % TAG_W] ^ pc[i];
        k++;
      end
    end
    return t;
  endfunction

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;

  assign lk_idx = lk_pc[IDX_LO +: IDX_W];
  assign up_idx = up_pc[IDX_LO +: IDX_W];
  assign lk_tag = fold_tag(lk_pc);
  assign up_tag = fold_tag(up_pc);

  logic             a_vld, b_vld;
  logic [TAG_W-1:0] a_tag, b_tag;
  logic [CNT_W-1:0] a_cnt, b_cnt;
  logic [CNT_W-1:0] new_cnt;
  logic             up_hit;

  ltt_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst(rst),
    .we(up_valid), .widx(up_idx), .wtag(up_tag), .wcnt(new_cnt),
    .ridx_a(lk_idx), .a_vld(a_vld), .a_tag(a_tag), .a_cnt(a_cnt),
    .ridx_b(up_idx), .b_vld(b_vld), .b_tag(b_tag), .b_cnt(b_cnt)
  );

  assign up_hit = b_vld && (b_tag == up_tag);

  ltt_step #(.CNT_W(CNT_W)) u_step (
    .old_cnt(b_cnt), .old_hit(up_hit), .correct(up_correct),
    .cls(ld_class_e'(up_class)), .inc_sp(cfg_inc_sp), .inc_gp(cfg_inc_gp),
    .new_cnt(new_cnt)
  );

  // same-cycle forwarding of the entry being written
  logic             byp;
  logic             e_vld;
  logic [TAG_W-1:0] e_tag;
  logic [CNT_W-1:0] e_cnt;

  assign byp   = up_valid && (up_idx == lk_idx);
  assign e_vld = byp ? 1'b1   : a_vld;
  assign e_tag = byp ? up_tag : a_tag;
  assign e_cnt = byp ? new_cnt : a_cnt;

  ltt_probe #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_probe (
    .clk(clk), .rst(rst), .req(lk_valid),
    .ent_vld(e_vld), .ent_tag(e_tag), .ent_cnt(e_cnt),
    .want_tag(lk_tag), .thresh(cfg_thresh),
    .rsp_valid(rsp_valid), .rsp_trust(rsp_trust), .rsp_level(rsp_level)
  );

  // R1: first lookup after reset, with no write in flight, sees an empty table
  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && lk_valid && !up_valid) |=> (rsp_level == '0));
  // R8: a correct outcome never lowers a hitting count (no wrap)
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_correct && up_hit) |-> (new_cnt >= b_cnt));
  // R6: a wrong outcome leaves nothing behind for the next lookup of that PC
  a_r6_clear_on_miss: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !up_correct && lk_valid && lk_pc == up_pc) |=> (rsp_level == '0));
  // R10: same PC updated and looked up together returns the updated count
  a_r10_bypass: assert property (@(posedge clk) disable iff (rst)
    (up_valid && lk_valid && lk_pc == up_pc) |=> (rsp_level == $past(new_cnt)));
endmodule

// File: tb/test_load_trust_table.sv
module test_load_trust_table;
  localparam int CNT_W = 4;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] cfg_thresh = '0, cfg_inc_sp = '0, cfg_inc_gp = '0;
  logic             lk_valid = 1'b0, up_valid = 1'b0, up_correct = 1'b0;
  logic [31:0]      lk_pc = '0, up_pc = '0;
  logic [1:0]       up_class = '0;
  logic             rsp_valid, rsp_trust;
  logic [CNT_W-1:0] rsp_level;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  load_trust_table i_load_trust_table (
    .clk(clk), .rst(rst),
    .cfg_thresh(cfg_thresh), .cfg_inc_sp(cfg_inc_sp), .cfg_inc_gp(cfg_inc_gp),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .up_valid(up_valid), .up_pc(up_pc), .up_class(up_class), .up_correct(up_correct),
    .rsp_valid(rsp_valid), .rsp_trust(rsp_trust), .rsp_level(rsp_level)
  );

  // reference model: index 64 entries, owner PC stands in for the tag
  bit      m_vld [64];
  int      m_pc  [64];
  int      m_cnt [64];

  function automatic int pidx(input logic [31:0] pc);
    return int'(pc[7:2]);
  endfunction

  function automatic int next_cnt(input logic [31:0] pc, input int cls, input bit ok);
    int base, step, s;
    base = (m_vld[pidx(pc)] && m_pc[pidx(pc)] == int'(pc)) ? m_cnt[pidx(pc)] : 0;
    if (!ok) return 0;
    step = (cls == 1) ? int'(cfg_inc_sp) : (cls == 2) ? int'(cfg_inc_gp) : 1;
    s = base + step;
    return (s > MAXC) ? MAXC : s;
  endfunction

  function automatic int peek(input logic [31:0] pc);
    return (m_vld[pidx(pc)] && m_pc[pidx(pc)] == int'(pc)) ? m_cnt[pidx(pc)] : 0;
  endfunction

  function automatic logic [31:0] pool_pc(input int idx, input int v);
    logic [31:0] p;
    p = 32'h0040_0000 | (32'(idx) << 2);
    if (v == 1) p = p ^ 32'h100;
    if (v == 2) p = p ^ 32'h200;
    return p;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one cycle: entered and left at a falling edge
  task automatic cyc(input bit lv, input logic [31:0] lpc, input bit uv,
                     input logic [31:0] upc, input int cls, input bit ok,
                     input string req);
    int exp_lvl;
    bit exp_tr;
    lk_valid = lv; lk_pc = lpc;
    up_valid = uv; up_pc = upc; up_class = 2'(cls); up_correct = ok;
    if (uv) begin
      m_cnt[pidx(upc)] = next_cnt(upc, cls, ok);
      m_pc[pidx(upc)]  = int'(upc);
      m_vld[pidx(upc)] = 1'b1;
    end
    exp_lvl = peek(lpc);
    exp_tr  = (exp_lvl >= int'(cfg_thresh));
    @(negedge clk);
    check("R2", "rsp_valid", int'(rsp_valid), int'(lv));
    if (lv) begin
      check(req, "rsp_level", int'(rsp_level), exp_lvl);
      check(req, "rsp_trust", int'(rsp_trust), int'(exp_tr));
    end
    lk_valid = 1'b0; up_valid = 1'b0;
  endtask

  task automatic set_cfg(input int x, input int y, input int z);
    cfg_thresh = CNT_W'(x); cfg_inc_sp = CNT_W'(y); cfg_inc_gp = CNT_W'(z);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] pa, pb, pc, pd;
    int dummy;
    dummy = $urandom(32'd1234);
    for (int i = 0; i < 64; i++) begin m_vld[i] = 0; m_pc[i] = 0; m_cnt[i] = 0; end
    pa = pool_pc(1, 0); pb = pool_pc(2, 0); pc = pool_pc(3, 0); pd = pool_pc(4, 0);
    set_cfg(4, 2, 2);
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: empty after reset
    cyc(1, pa, 0, 0, 0, 0, "R1");
    cyc(1, pd, 0, 0, 0, 0, "R1");
    // R3: ordinary steps of one, R7 threshold crossing at 4
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, pa, 0, 1, "R3");
    cyc(1, pa, 0, 0, 0, 0, "R3");
    cyc(0, 0, 1, pa, 0, 1, "R3");
    cyc(1, pa, 0, 0, 0, 0, "R7");
    // R4: stack step
    cyc(0, 0, 1, pb, 1, 1, "R4");
    cyc(1, pb, 0, 0, 0, 0, "R4");
    cyc(0, 0, 1, pb, 1, 1, "R4");
    cyc(1, pb, 0, 0, 0, 0, "R4");
    // R5: global step, then class 3 behaves as ordinary
    cyc(0, 0, 1, pc, 2, 1, "R5");
    cyc(1, pc, 0, 0, 0, 0, "R5");
    cyc(0, 0, 1, pc, 3, 1, "R5");
    cyc(1, pc, 0, 0, 0, 0, "R5");
    // R6: wrong prediction clears, even for stack class
    cyc(0, 0, 1, pa, 0, 0, "R6");
    cyc(1, pa, 0, 0, 0, 0, "R6");
    cyc(0, 0, 1, pb, 1, 0, "R6");
    cyc(1, pb, 0, 0, 0, 0, "R6");
    // R8: saturation with the (8,4,4) setting
    set_cfg(8, 4, 4);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, pb, 1, 1, "R8");
    cyc(1, pb, 0, 0, 0, 0, "R8");
    // R9: alias at the same index reads zero and takes over from zero
    cyc(0, 0, 1, pa, 0, 1, "R9");
    cyc(1, pool_pc(1, 1), 0, 0, 0, 0, "R9");
    cyc(0, 0, 1, pool_pc(1, 1), 0, 1, "R9");
    cyc(1, pool_pc(1, 1), 0, 0, 0, 0, "R9");
    cyc(1, pa, 0, 0, 0, 0, "R9");
    // R10: same-cycle update and lookup
    cyc(1, pc, 1, pc, 2, 1, "R10");
    cyc(1, pc, 1, pc, 0, 0, "R10");
    // R7/R11: zero threshold and zero step
    set_cfg(0, 0, 0);
    cyc(1, pd, 0, 0, 0, 0, "R7");
    cyc(0, 0, 1, pb, 1, 1, "R11");
    cyc(1, pb, 0, 0, 0, 0, "R11");

    // random traffic under each required setting
    for (int s = 0; s < 5; s++) begin
      case (s)
        0: set_cfg(4, 2, 2);
        1: set_cfg(8, 4, 4);
        2: set_cfg(2, 1, 1);
        3: set_cfg(1, 1, 1);
        default: set_cfg(0, 0, 0);
      endcase
      for (int n = 0; n < 800; n++) begin
        logic [31:0] l, u;
        bit lv, uv, ok;
        int cls;
        l   = pool_pc(int'($urandom_range(0, 7)), int'($urandom_range(0, 2)));
        u   = pool_pc(int'($urandom_range(0, 7)), int'($urandom_range(0, 2)));
        lv  = ($urandom_range(0, 3) != 0);
        uv  = ($urandom_range(0, 2) != 0);
        ok  = ($urandom_range(0, 9) < 8);
        cls = int'($urandom_range(0, 3));
        cyc(lv, l, uv, u, cls, ok, (uv && pidx(l) == pidx(u)) ? "R10" : "R11");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule